// File: doc/BRIEF.md
# Reservation Unit for Load-Reserved / Store-Conditional

This block sits between a 32-bit core's execute stage and a single-port word memory. It runs the two word-sized reservation instructions. A load-reserved reads an aligned word, writes it sign-extended to the destination register, and records both the address and the word it read as the reservation. A store-conditional first checks that a reservation exists for the same address. It then re-reads memory and writes the new word only if memory still holds the value recorded at load-reserved. The destination register receives 0 on success and 1 on failure. The reservation is therefore checked against the stored value, like a compare-and-exchange, and not only against the address.

The unit decodes the instruction word itself and turns the ordering bits into one-cycle acquire and release fence strobes for the rest of the pipeline. An external invalidate input drops the reservation at any time. A misaligned address raises a one-cycle exception pulse and does nothing else. The core sees `busy` while an operation is in flight. Requests presented while busy are not taken.

Top module: `lrsc_unit`

## Requirements
- R1: A request is taken only when opcode bits 6:0 are 0101111, bits 14:12 are 010, and either bits 31:27 are 00010 with bits 24:20 all zero (load-reserved) or bits 31:27 are 00011 (store-conditional). Any other word presented with `req_valid` causes no busy cycle, no memory access, no fence strobe, no register write and no change to the reservation.
- R2: Load-reserved reads the word at `req_rs1`, writes it sign-extended to `rd_data` with `rd_idx` equal to instruction bits 11:7, and records that address and word as the valid reservation.
- R3: For load-reserved, bit 25 set gives one `fence_rel` cycle before the read request, and bit 26 set gives one `fence_acq` cycle after the read completes and before the register write.
- R4: A store-conditional with no valid reservation, or with an address different from the reserved one, makes no memory access and writes 1. If bit 26 and/or bit 25 is set, the matching strobes are raised together in one cycle before the write-back.
- R5: A store-conditional whose address matches a valid reservation reads memory. If the word equals the reserved value, it writes `req_rs2` to that address and returns 0. Otherwise it returns 1 and writes nothing. No fence strobes are raised on this path.
- R6: Every store-conditional that completes clears the reservation, so a second one without a new load-reserved fails.
- R7: `invalidate` clears the reservation at the next edge. When it coincides with the read completion of a load-reserved, the invalidate wins and the reservation is left invalid.
- R8: If bits 1:0 of the address are non-zero, a taken request raises `exc_misaligned` for exactly the next cycle. It makes no memory access, writes no register, never raises `busy`, and leaves the reservation unchanged.
- R9: `busy` is high from the cycle after a request is taken through the cycle in which `rd_we` is high, and low in the cycle after. Requests presented while busy are ignored.
- R10: Once `mem_req` is raised, it stays high with stable `mem_addr`, `mem_we` and `mem_wdata` until the cycle in which `mem_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Instruction presented this cycle |
| req_instr | input | 32 | Instruction word |
| req_rs1 | input | XLEN | Address operand |
| req_rs2 | input | XLEN | Store data operand (low 32 bits used) |
| invalidate | input | 1 | Drop the reservation |
| busy | output | 1 | Operation in flight |
| rd_we | output | 1 | Destination register write strobe |
| rd_idx | output | 5 | Destination register index |
| rd_data | output | XLEN | Destination register value |
| fence_acq | output | 1 | Acquire fence strobe |
| fence_rel | output | 1 | Release fence strobe |
| exc_misaligned | output | 1 | Misaligned-address exception pulse |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | XLEN | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ready | input | 1 | Memory accepts or completes the request this cycle |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ready` |

## Verification
Two functions can land on the same clock edge: the invalidate input, and the reservation capture that ends a load-reserved read. The bench makes them coincide by deriving `invalidate` from the memory handshake itself, so it rises exactly in the cycle the read completes. The result is judged at the ports. The loaded word must still reach the register, and the next store-conditional to that address must return 1 without touching memory. A second overlap is a new request held on the inputs during a busy operation. It is judged by the absence of any extra memory traffic, and by a later store-conditional still finding the original reservation.

// File: rtl/lrsc_pkg.sv
`timescale 1ns/1ps
// Shared encodings and types for the reservation unit.
// Assumes a 32-bit instruction word and 32-bit memory words.
package lrsc_pkg;
    localparam int          WORD_W     = 32;
    localparam logic [6:0]  OPC_ATOMIC = 7'b0101111;
    localparam logic [2:0]  F3_WORD    = 3'b010;
    localparam logic [4:0]  F5_LOADRES = 5'b00010;
    localparam logic [4:0]  F5_STORECD = 5'b00011;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_RD,
        ST_POST,
        ST_FAILF,
        ST_WR,
        ST_WB
    } lrsc_state_e;

    typedef struct packed {
        logic       is_lr;
        logic       is_sc;
        logic       aq;
        logic       rl;
        logic [4:0] rd;
    } lrsc_dec_t;
endpackage

// File: rtl/lrsc_decode.sv
`timescale 1ns/1ps
// Instruction decoder: recognises the word-sized load-reserved and
// store-conditional encodings and extracts ordering bits and rd.
// Assumes nothing about validity; the caller qualifies with req_valid.
module lrsc_decode
    import lrsc_pkg::*;
(
    input  logic [31:0] instr,
    output lrsc_dec_t   dec
);
    logic group_ok;
    logic unused_fields;

    assign unused_fields = ^instr[19:15];

    // Purpose: classify the instruction word.
    always_comb begin
        group_ok  = (instr[6:0] == OPC_ATOMIC) && (instr[14:12] == F3_WORD);
        dec.is_lr = group_ok && (instr[31:27] == F5_LOADRES) && (instr[24:20] == 5'd0);
        dec.is_sc = group_ok && (instr[31:27] == F5_STORECD);
        dec.aq    = instr[26];
        dec.rl    = instr[25];
        dec.rd    = instr[11:7];
    end
endmodule

// File: rtl/lrsc_resv.sv
`timescale 1ns/1ps
// Reservation register: holds address and captured word plus a valid flag.
// Assumes set and drop never target conflicting goals; a drop or an
// invalidate always beats a set in the same cycle.
module lrsc_resv #(
    parameter int XLEN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set,
    input  logic [XLEN-1:0]   set_addr,
    input  logic [31:0]       set_val,
    input  logic              drop,
    input  logic              inv,
    output logic              valid,
    output logic [XLEN-1:0]   addr,
    output logic [31:0]       val
);
    // Purpose: update the reservation, clearing having priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
            addr  <= '0;
            val   <= '0;
        end else if (inv || drop) begin
            valid <= 1'b0;
        end else if (set) begin
            valid <= 1'b1;
            addr  <= set_addr;
            val   <= set_val;
        end
    end

    // R7
    inv_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inv |=> !valid);
endmodule

// File: rtl/lrsc_ctrl.sv
`timescale 1ns/1ps
// Sequencer for load-reserved / store-conditional. Drives the memory
// handshake, fence strobes, register write-back and reservation updates.
// Assumes memory holds mem_rdata valid in the cycle mem_ready is high.
module lrsc_ctrl
    import lrsc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  lrsc_dec_t         dec,
    input  logic [XLEN-1:0]   rs1,
    input  logic [XLEN-1:0]   rs2,
    input  logic              invalidate,
    input  logic              resv_valid,
    input  logic [XLEN-1:0]   resv_addr,
    input  logic [31:0]       resv_val,
    output logic              resv_set,
    output logic [XLEN-1:0]   resv_set_addr,
    output logic [31:0]       resv_set_val,
    output logic              resv_drop,
    output logic              mem_req,
    output logic              mem_we,
    output logic [XLEN-1:0]   mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_ready,
    input  logic [31:0]       mem_rdata,
    output logic              busy,
    output logic              rd_we,
    output logic [4:0]        rd_idx,
    output logic [XLEN-1:0]   rd_data,
    output logic              fence_acq,
    output logic              fence_rel,
    output logic              exc_misaligned
);
    localparam logic [XLEN-1:0] SC_FAIL = XLEN'(1);

    lrsc_state_e     state_q;
    logic            is_sc_q;
    logic            aq_q;
    logic            rl_q;
    logic [4:0]      rd_q;
    logic [XLEN-1:0] addr_q;
    logic [31:0]     wdata_q;
    logic [XLEN-1:0] result_q;
    logic            exc_q;
    logic            accept;
    logic            misal;
    logic            hit;
    logic [XLEN-1:0] load_ext;

    // Purpose: widen the loaded word with its sign bit when XLEN is wider.
    generate
        if (XLEN > WORD_W) begin : g_ext
            assign load_ext = {{(XLEN-WORD_W){mem_rdata[WORD_W-1]}}, mem_rdata};
        end else begin : g_noext
            assign load_ext = mem_rdata;
        end
    endgenerate

    assign accept = req_valid && (state_q == ST_IDLE) && (dec.is_lr || dec.is_sc);
    assign misal  = |rs1[1:0];
    assign hit    = resv_valid && !invalidate && (resv_addr == rs1);

    // Purpose: step the operation sequence and hold its operands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            is_sc_q  <= 1'b0;
            aq_q     <= 1'b0;
            rl_q     <= 1'b0;
            rd_q     <= '0;
            addr_q   <= '0;
            wdata_q  <= '0;
            result_q <= '0;
            exc_q    <= 1'b0;
        end else begin
            exc_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        is_sc_q <= dec.is_sc;
                        aq_q    <= dec.aq;
                        rl_q    <= dec.rl;
                        rd_q    <= dec.rd;
                        addr_q  <= rs1;
                        wdata_q <= rs2[WORD_W-1:0];
                        if (misal) begin
                            exc_q <= 1'b1;
                        end else if (dec.is_lr) begin
                            state_q <= dec.rl ? ST_PRE : ST_RD;
                        end else if (hit) begin
                            state_q <= ST_RD;
                        end else begin
                            result_q <= SC_FAIL;
                            state_q  <= (dec.aq || dec.rl) ? ST_FAILF : ST_WB;
                        end
                    end
                end
                ST_PRE: state_q <= ST_RD;
                ST_RD: begin
                    if (mem_ready) begin
                        if (!is_sc_q) begin
                            result_q <= load_ext;
                            state_q  <= aq_q ? ST_POST : ST_WB;
                        end else if (mem_rdata == resv_val) begin
                            state_q <= ST_WR;
                        end else begin
                            result_q <= SC_FAIL;
                            state_q  <= ST_WB;
                        end
                    end
                end
                ST_WR: begin
                    if (mem_ready) begin
                        result_q <= '0;
                        state_q  <= ST_WB;
                    end
                end
                ST_POST, ST_FAILF: state_q <= ST_WB;
                ST_WB:             state_q <= ST_IDLE;
                default:           state_q <= ST_IDLE;
            endcase
        end
    end

    // Purpose: decode state into handshake, strobes and reservation updates.
    always_comb begin
        mem_req        = (state_q == ST_RD) || (state_q == ST_WR);
        mem_we         = (state_q == ST_WR);
        mem_addr       = addr_q;
        mem_wdata      = wdata_q;
        busy           = (state_q != ST_IDLE);
        rd_we          = (state_q == ST_WB);
        rd_idx         = rd_q;
        rd_data        = result_q;
        fence_rel      = (state_q == ST_PRE)  || ((state_q == ST_FAILF) && rl_q);
        fence_acq      = (state_q == ST_POST) || ((state_q == ST_FAILF) && aq_q);
        exc_misaligned = exc_q;
        resv_set       = (state_q == ST_RD) && mem_ready && !is_sc_q;
        resv_set_addr  = addr_q;
        resv_set_val   = mem_rdata;
        resv_drop      = (state_q == ST_WB) && is_sc_q;
    end

    // R10
    handshake_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    // R8
    misaligned_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_misaligned |-> ($past(req_valid) && !busy && !mem_req));

    // R9
    busy_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_we |=> !busy);
endmodule

// File: rtl/lrsc_unit.sv
`timescale 1ns/1ps
// Top of the reservation unit: decoder, sequencer and reservation register.
// Assumes a single requester and a memory that completes each request
// with mem_ready; no caching or multi-hart arbitration.
module lrsc_unit
    import lrsc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [31:0]       req_instr,
    input  logic [XLEN-1:0]   req_rs1,
    input  logic [XLEN-1:0]   req_rs2,
    input  logic              invalidate,
    output logic              busy,
    output logic              rd_we,
    output logic [4:0]        rd_idx,
    output logic [XLEN-1:0]   rd_data,
    output logic              fence_acq,
    output logic              fence_rel,
    output logic              exc_misaligned,
    output logic              mem_req,
    output logic              mem_we,
    output logic [XLEN-1:0]   mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_ready,
    input  logic [31:0]       mem_rdata
);
    lrsc_dec_t       dec;
    logic            rv_valid;
    logic [XLEN-1:0] rv_addr;
    logic [31:0]     rv_val;
    logic            rv_set;
    logic [XLEN-1:0] rv_set_addr;
    logic [31:0]     rv_set_val;
    logic            rv_drop;

    lrsc_decode i_decode (
        .instr (req_instr),
        .dec   (dec)
    );

    lrsc_resv #(.XLEN(XLEN)) i_resv (
        .clk      (clk),
        .rst_n    (rst_n),
        .set      (rv_set),
        .set_addr (rv_set_addr),
        .set_val  (rv_set_val),
        .drop     (rv_drop),
        .inv      (invalidate),
        .valid    (rv_valid),
        .addr     (rv_addr),
        .val      (rv_val)
    );

    lrsc_ctrl #(.XLEN(XLEN)) i_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .req_valid      (req_valid),
        .dec            (dec),
        .rs1            (req_rs1),
        .rs2            (req_rs2),
        .invalidate     (invalidate),
        .resv_valid     (rv_valid),
        .resv_addr      (rv_addr),
        .resv_val       (rv_val),
        .resv_set       (rv_set),
        .resv_set_addr  (rv_set_addr),
        .resv_set_val   (rv_set_val),
        .resv_drop      (rv_drop),
        .mem_req        (mem_req),
        .mem_we         (mem_we),
        .mem_addr       (mem_addr),
        .mem_wdata      (mem_wdata),
        .mem_ready      (mem_ready),
        .mem_rdata      (mem_rdata),
        .busy           (busy),
        .rd_we          (rd_we),
        .rd_idx         (rd_idx),
        .rd_data        (rd_data),
        .fence_acq      (fence_acq),
        .fence_rel      (fence_rel),
        .exc_misaligned (exc_misaligned)
    );

    // R5
    sc_write_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (mem_addr == rv_addr));
endmodule

// File: tb/test_lrsc_unit.sv
`timescale 1ns/1ps
module test_lrsc_unit;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic [31:0] req_instr;
    logic [31:0] req_rs1;
    logic [31:0] req_rs2;
    logic        invalidate;
    logic        busy;
    logic        rd_we;
    logic [4:0]  rd_idx;
    logic [31:0] rd_data;
    logic        fence_acq;
    logic        fence_rel;
    logic        exc_misaligned;
    logic        mem_req;
    logic        mem_we;
    logic [31:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        mem_ready;
    logic [31:0] mem_rdata;

    logic        inv_force = 1'b0;
    logic        inv_arm   = 1'b0;
    logic        poke_en   = 1'b0;
    logic [5:0]  poke_a    = '0;
    logic [31:0] poke_d    = '0;
    logic [31:0] mem [64];
    logic [2:0]  wcnt = '0;
    int          lat = 0;
    int          checks = 0;
    int          failures = 0;

    // behavioural reservation model
    bit          mv = 1'b0;
    logic [31:0] ma = '0;
    logic [31:0] mval = '0;

    always #10 clk = ~clk;

    lrsc_unit i_lrsc_unit (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_instr(req_instr),
        .req_rs1(req_rs1), .req_rs2(req_rs2), .invalidate(invalidate),
        .busy(busy), .rd_we(rd_we), .rd_idx(rd_idx), .rd_data(rd_data),
        .fence_acq(fence_acq), .fence_rel(fence_rel), .exc_misaligned(exc_misaligned),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ready(mem_ready), .mem_rdata(mem_rdata)
    );

    // memory model with programmable latency
    assign mem_ready  = mem_req && (wcnt == 3'(lat));
    assign mem_rdata  = mem[mem_addr[7:2]];
    assign invalidate = inv_force || (inv_arm && mem_req && mem_ready && !mem_we);

    always @(posedge clk) begin
        if (poke_en) mem[poke_a] <= poke_d;
        if (mem_req && mem_we && mem_ready) mem[mem_addr[7:2]] <= mem_wdata;
        if (mem_req && !mem_ready) wcnt <= wcnt + 3'd1;
        else wcnt <= '0;
    end

    function automatic logic [31:0] mk(input logic [4:0] f5, input bit aq, input bit rl,
                                       input logic [4:0] f2, input logic [2:0] f3,
                                       input logic [4:0] rd);
        return {f5, aq, rl, f2, 5'd3, f3, rd, 7'b0101111};
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic check_s(input bit ok, input string tag, input string what,
                           input string act, input string exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=\"%s\" expected=\"%s\"", tag, what, act, exp);
        end
    endtask

    task automatic poke(input logic [31:0] a, input logic [31:0] d);
        poke_en = 1'b1; poke_a = a[7:2]; poke_d = d;
        @(negedge clk);
        poke_en = 1'b0;
    endtask

    // Drive one request and record per-cycle events until write-back or exception.
    task automatic run_op(input logic [31:0] instr, input logic [31:0] a, input logic [31:0] b,
                          input int l, input bit hold, input string exp_ev, input bit exp_wb,
                          input logic [31:0] exp_d, input string tag);
        string       ev;
        logic [31:0] dval;
        logic [4:0]  didx;
        bit          done;
        bit          bad;
        ev = ""; dval = '0; didx = '0; done = 1'b0; bad = 1'b0;
        lat = l;
        req_instr = instr; req_rs1 = a; req_rs2 = b; req_valid = 1'b1;
        @(negedge clk);
        if (!hold) req_valid = 1'b0;
        for (int c = 0; c < 40 && !done; c++) begin
            if (fence_rel && fence_acq) ev = {ev, "B"};
            else begin
                if (fence_rel) ev = {ev, "R"};
                if (fence_acq) ev = {ev, "A"};
            end
            if (mem_req && mem_ready) ev = {ev, mem_we ? "w" : "r"};
            if (exc_misaligned) begin
                ev = {ev, "X"}; done = 1'b1;
                if (busy) bad = 1'b1;
            end
            if (rd_we) begin
                ev = {ev, "D"}; dval = rd_data; didx = rd_idx; done = 1'b1;
                req_valid = 1'b0;
            end
            if (!rd_we && !exc_misaligned && !busy) bad = 1'b1;
            @(negedge clk);
        end
        req_valid = 1'b0;
        check(done, tag, "operation completed", {31'd0, done}, 32'd1);
        check_s(ev == exp_ev, tag, "event order", ev, exp_ev);
        if (exp_wb) begin
            check(dval == exp_d, tag, "rd_data", dval, exp_d);
            check(didx == instr[11:7], tag, "rd_idx", {27'd0, didx}, {27'd0, instr[11:7]});
        end
        check(!bad && !busy && !mem_req, "R9", "busy window", {29'd0, bad, busy, mem_req}, 32'd0);
    endtask

    task automatic do_lr(input logic [31:0] a, input bit aq, input bit rl, input int l,
                         input bit hold, input string tag);
        string       e;
        logic [31:0] w;
        e = "";
        if (rl) e = "R";
        e = {e, "r"};
        if (aq) e = {e, "A"};
        e = {e, "D"};
        w = mem[a[7:2]];
        run_op(mk(5'b00010, aq, rl, 5'd0, 3'b010, 5'd7), a, 32'd0, l, hold, e, 1'b1, w, tag);
        if (!inv_arm) begin
            mv = 1'b1; ma = a; mval = w;
        end else begin
            mv = 1'b0;
        end
    endtask

    task automatic do_sc(input logic [31:0] a, input logic [31:0] d, input bit aq, input bit rl,
                         input int l, input string tag);
        string       e;
        logic [31:0] ed;
        logic [31:0] old;
        bit          wr;
        wr = 1'b0;
        old = mem[a[7:2]];
        if (!(mv && ma == a)) begin
            e = "";
            if (aq && rl) e = "B";
            else begin
                if (rl) e = "R";
                if (aq) e = {e, "A"};
            end
            e = {e, "D"}; ed = 32'd1;
        end else if (old == mval) begin
            e = "rwD"; ed = 32'd0; wr = 1'b1;
        end else begin
            e = "rD"; ed = 32'd1;
        end
        run_op(mk(5'b00011, aq, rl, 5'd4, 3'b010, 5'd9), a, d, l, 1'b0, e, 1'b1, ed, tag);
        mv = 1'b0;
        check(mem[a[7:2]] == (wr ? d : old), tag, "memory word", mem[a[7:2]], wr ? d : old);
    endtask

    task automatic do_mis(input logic [31:0] instr, input logic [31:0] a, input string tag);
        run_op(instr, a, 32'h5555_5555, 0, 1'b0, "X", 1'b0, 32'd0, tag);
    endtask

    task automatic do_ignored(input logic [31:0] instr, input logic [31:0] a, input string tag);
        bit bad;
        bad = 1'b0;
        req_instr = instr; req_rs1 = a; req_rs2 = 32'h1234_5678; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (4) begin
            if (busy || mem_req || rd_we || exc_misaligned || fence_acq || fence_rel) bad = 1'b1;
            @(negedge clk);
        end
        check(!bad, tag, "ignored word left outputs idle", {31'd0, bad}, 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL R9 watchdog: actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = 32'h0;
        rst_n = 1'b0; req_valid = 1'b0; req_instr = '0; req_rs1 = '0; req_rs2 = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state
        check(!busy && !rd_we && !mem_req && !exc_misaligned && !fence_acq && !fence_rel,
              "R9", "reset outputs idle",
              {26'd0, busy, rd_we, mem_req, exc_misaligned, fence_acq, fence_rel}, 32'd0);

        poke(32'h10, 32'h8000_1234);
        poke(32'h20, 32'd5);
        poke(32'h24, 32'd7);

        // R4: no reservation, both ordering bits -> one combined strobe cycle
        do_sc(32'h10, 32'hDEAD_BEEF, 1'b1, 1'b1, 0, "R4");
        // R2: load-reserved of a negative word
        do_lr(32'h10, 1'b0, 1'b0, 0, 1'b0, "R2");
        // R5: matching store-conditional succeeds with memory latency
        do_sc(32'h10, 32'h0000_AAAA, 1'b0, 1'b0, 2, "R5");
        // R6: second store-conditional fails
        do_sc(32'h10, 32'h0000_BBBB, 1'b0, 1'b0, 0, "R6");
        // R3: both fences around the read
        do_lr(32'h20, 1'b1, 1'b1, 1, 1'b0, "R3");
        // R5: value changed behind the reservation -> fail without write
        poke(32'h20, 32'd9);
        do_sc(32'h20, 32'h0000_0F0F, 1'b0, 1'b0, 1, "R5");
        // R4: address mismatch with acquire bit
        do_lr(32'h24, 1'b0, 1'b0, 0, 1'b0, "R2");
        do_sc(32'h20, 32'h0000_0101, 1'b1, 1'b0, 0, "R4");
        // R7: invalidate pulse between the pair
        do_lr(32'h24, 1'b0, 1'b0, 0, 1'b0, "R2");
        inv_force = 1'b1;
        @(negedge clk);
        inv_force = 1'b0;
        mv = 1'b0;
        do_sc(32'h24, 32'h0000_0202, 1'b0, 1'b0, 0, "R7");
        // R7: invalidate in the same cycle as the reservation capture
        inv_arm = 1'b1;
        do_lr(32'h24, 1'b0, 1'b0, 1, 1'b0, "R7");
        inv_arm = 1'b0;
        do_sc(32'h24, 32'h0000_0303, 1'b0, 1'b0, 0, "R7");
        // R8: misaligned requests, reservation kept
        do_lr(32'h24, 1'b0, 1'b0, 0, 1'b0, "R2");
        do_mis(mk(5'b00010, 1'b0, 1'b0, 5'd0, 3'b010, 5'd7), 32'h26, "R8");
        do_mis(mk(5'b00011, 1'b1, 1'b1, 5'd4, 3'b010, 5'd9), 32'h25, "R8");
        do_sc(32'h24, 32'h0000_0404, 1'b0, 1'b0, 0, "R8");
        // R1: foreign encodings ignored, reservation kept
        do_lr(32'h20, 1'b0, 1'b0, 0, 1'b0, "R2");
        do_ignored(mk(5'b00010, 1'b0, 1'b0, 5'd1, 3'b010, 5'd7), 32'h24, "R1");
        do_ignored(mk(5'b00000, 1'b0, 1'b0, 5'd4, 3'b010, 5'd7), 32'h24, "R1");
        do_ignored(mk(5'b00011, 1'b0, 1'b0, 5'd4, 3'b011, 5'd7), 32'h20, "R1");
        do_ignored({mk(5'b00010, 1'b0, 1'b0, 5'd0, 3'b010, 5'd7)} ^ 32'h0000_0004, 32'h24, "R1");
        do_sc(32'h20, 32'h0000_0505, 1'b0, 1'b0, 0, "R1");
        // R9: request held while busy is not taken
        do_lr(32'h24, 1'b0, 1'b0, 2, 1'b1, "R9");
        do_sc(32'h24, 32'h0000_0606, 1'b0, 1'b0, 0, "R9");
        // R10: long latency on both read and write of a successful pair
        do_lr(32'h30, 1'b1, 1'b0, 5, 1'b0, "R10");
        do_sc(32'h30, 32'h7777_0000, 1'b0, 1'b1, 5, "R10");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule